// File: doc/BRIEF.md
# Prioritized Interrupt Request Resolver

This block is the arbitration core of an eight-line interrupt controller. Each cycle it samples a vector of request lines into a request register. In level mode a line counts as a request while it is high. In edge mode it counts only on a low-to-high transition. The block then selects the highest-priority unmasked request. That request is offered to the processor only when it outranks every routine currently in service. On an acknowledge, the selected line moves from the request register into the in-service register.

In-service bits are released in one of three ways: a non-specific end-of-interrupt, which releases the highest-priority routine in service; a specific end-of-interrupt naming a line; or automatically at acknowledge time. Priority is circular. A base pointer names the line that currently has the highest rank, and the ranks of the other lines follow it in ascending order with wrap-around. Software can load the pointer directly. When rotation is enabled, the pointer moves to the line after the one just released, so the released line becomes the lowest in rank.

The request register and the in-service register are brought out for readback. Bus decoding and cascading are handled by the surrounding logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, the request and in-service registers read zero, no request is offered, and line 0 holds the top rank.
- R2: With the base pointer at 0 and nothing in service, the offered index is the lowest-numbered unmasked request; with no request, nothing is offered.
- R3: A masked line still sets its bit in the request register but is never the offered index; with every requesting line masked, nothing is offered.
- R4: A request is offered only if its rank is strictly higher than the rank of every bit set in the in-service register; an equal or lower rank waits.
- R5: An acknowledge while a request is offered sets that line's in-service bit and clears its request bit on the same clock edge.
- R6: A non-specific end-of-interrupt clears the in-service bit with the highest rank. A specific end-of-interrupt clears the bit at the given index.
- R7: With automatic release enabled, an acknowledge leaves no in-service bit set and still clears the request bit.
- R8: In level mode, the request register follows the sampled line level. A line still high after its routine is released is offered again.
- R9: In edge mode, only a low-to-high transition sets a request bit. A line held high after acknowledge sets nothing new until it has been seen low.
- R10: Loading the base pointer with line t gives line t the top rank, with ranks falling through t+1, t+2 and onward, modulo 8.
- R11: With rotation enabled, releasing line k (by end-of-interrupt or by automatic release) moves the base pointer to k+1 modulo 8, so that line k becomes the lowest in rank.
- R12: An acknowledge while nothing is offered changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 8 | Raw request lines |
| edge_mode | input | 1 | 1 = edge capture, 0 = level capture |
| mask | input | 8 | 1 blocks the line from arbitration |
| auto_release | input | 1 | 1 = release the in-service bit at acknowledge |
| rotate_en | input | 1 | 1 = move the base pointer after each release |
| ack | input | 1 | Acknowledge of the offered request |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = clear the bit at eoi_index, 0 = clear the highest-rank bit |
| eoi_index | input | 3 | Line index for a specific end-of-interrupt |
| prio_load | input | 1 | Load the base pointer |
| prio_top | input | 3 | Line that receives the top rank on load |
| irq_pending | output | 1 | A request is offered |
| irq_index | output | 3 | Index of the offered request |
| req_reg | output | 8 | Request register |
| isr_reg | output | 8 | In-service register |

## Verification
The hardest states to reach are those where the in-service register holds several nested bits. Non-specific release order and in-service blocking can only be observed there. The bench builds these states in edge mode. It raises one new line at a time, each of higher rank than the last, and acknowledges each one, which stacks three bits. It then releases them one by one. Rotation is checked with two lines held high in level mode, so that after each release the previously losing line must win while the other line is still requesting. Blocking is checked by sweeping all 255 request patterns against a line held in service.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  typedef enum logic {
    CAP_LEVEL = 1'b0,
    CAP_EDGE  = 1'b1
  } cap_mode_e;

  // Rank of a line relative to the base pointer: 0 is the top rank.
  function automatic int unsigned rank_of(int unsigned idx, int unsigned top, int unsigned n);
    return (idx + n - top) % n;
  endfunction

  // Line that follows idx in circular order.
  function automatic int unsigned next_line(int unsigned idx, int unsigned n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
  import irq_res_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_line,
  input  logic         edge_mode,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] req_q
);

  logic [N-1:0] line_prev_q;
  logic [N-1:0] rise_vec;
  logic [N-1:0] req_d;
  cap_mode_e    mode;

  assign mode     = cap_mode_e'(edge_mode);
  assign rise_vec = irq_line & ~line_prev_q;

  always_comb begin
    if (mode == CAP_EDGE) begin
      req_d = (req_q | rise_vec) & ~clr_vec;
    end else begin
      req_d = irq_line & ~clr_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= '0;
      line_prev_q <= '0;
    end else begin
      req_q       <= req_d;
      line_prev_q <= irq_line;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_edge_chk
    AST_EDGE_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_q[g]) && $past(edge_mode)) |-> ($past(irq_line[g]) && !$past(irq_line[g], 2)))
      else $error("edge request without rising input"); // R9
  end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_res_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_vec,
  input  logic [N-1:0]     mask_vec,
  input  logic [N-1:0]     isr_vec,
  input  logic [IDX_W-1:0] top_idx,
  output logic             pend,
  output logic [IDX_W-1:0] win_idx,
  output logic             isr_any,
  output logic [IDX_W-1:0] isr_hi_idx
);

  logic [N-1:0] cand_vec;
  logic         win_found;

  assign cand_vec = req_vec & ~mask_vec;

  always_comb begin
    int unsigned line;
    win_found  = 1'b0;
    win_idx    = '0;
    isr_any    = 1'b0;
    isr_hi_idx = '0;
    for (int unsigned k = 0; k < N; k++) begin
      line = (32'(top_idx) + k) % N;
      if (!win_found && cand_vec[line]) begin
        win_found = 1'b1;
        win_idx   = IDX_W'(line);
      end
      if (!isr_any && isr_vec[line]) begin
        isr_any    = 1'b1;
        isr_hi_idx = IDX_W'(line);
      end
    end
    pend = win_found &&
           (!isr_any || rank_of(32'(win_idx), 32'(top_idx), N) < rank_of(32'(isr_hi_idx), 32'(top_idx), N));
  end

endmodule

// File: rtl/irq_service_ctl.sv
module irq_service_ctl
  import irq_res_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             pend,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             auto_release,
  input  logic             rotate_en,
  input  logic             eoi_valid,
  input  logic             eoi_specific,
  input  logic [IDX_W-1:0] eoi_index,
  input  logic             isr_any,
  input  logic [IDX_W-1:0] isr_hi_idx,
  input  logic             prio_load,
  input  logic [IDX_W-1:0] prio_top,
  output logic [N-1:0]     isr_q,
  output logic [IDX_W-1:0] top_q,
  output logic [N-1:0]     req_clr_vec
);

  logic             ack_fire;
  logic             rel_hit;
  logic [IDX_W-1:0] rel_idx;
  logic [N-1:0]     rel_vec;
  logic [N-1:0]     set_vec;
  logic [N-1:0]     isr_d;
  logic [IDX_W-1:0] top_d;

  always_comb begin
    ack_fire    = ack && pend;
    req_clr_vec = '0;
    set_vec     = '0;
    if (ack_fire) begin
      req_clr_vec[win_idx] = 1'b1;
      if (!auto_release) set_vec[win_idx] = 1'b1;
    end

    rel_hit = 1'b0;
    rel_idx = eoi_index;
    if (eoi_valid) begin
      if (eoi_specific) begin
        rel_idx = eoi_index;
        rel_hit = isr_q[eoi_index];
      end else begin
        rel_idx = isr_hi_idx;
        rel_hit = isr_any;
      end
    end
    rel_vec = '0;
    if (rel_hit) rel_vec[rel_idx] = 1'b1;

    isr_d = (isr_q & ~rel_vec) | set_vec;

    top_d = top_q;
    if (prio_load) begin
      top_d = prio_top;
    end else if (rotate_en) begin
      if (rel_hit) begin
        top_d = IDX_W'(next_line(32'(rel_idx), N));
      end else if (ack_fire && auto_release) begin
        top_d = IDX_W'(next_line(32'(win_idx), N));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      top_q <= '0;
    end else begin
      isr_q <= isr_d;
      top_q <= top_d;
    end
  end

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend && !auto_release) |=> isr_q[$past(win_idx)])
    else $error("acknowledged line not in service"); // R5

  AST_AUTO_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend && auto_release) |=> !isr_q[$past(win_idx)])
    else $error("auto release left a bit in service"); // R7

  AST_SPEC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_specific && !(ack && pend && win_idx == eoi_index)) |=> !isr_q[$past(eoi_index)])
    else $error("specific release did not clear"); // R6

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate_en && !prio_load && eoi_valid && eoi_specific && isr_q[eoi_index])
      |=> top_q == IDX_W'(next_line(32'($past(eoi_index)), N)))
    else $error("rotation did not follow release"); // R11

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pend && !eoi_valid) |=> $stable(isr_q))
    else $error("acknowledge without offer changed service"); // R12

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_line,
  input  logic             edge_mode,
  input  logic [N-1:0]     mask,
  input  logic             auto_release,
  input  logic             rotate_en,
  input  logic             ack,
  input  logic             eoi_valid,
  input  logic             eoi_specific,
  input  logic [IDX_W-1:0] eoi_index,
  input  logic             prio_load,
  input  logic [IDX_W-1:0] prio_top,
  output logic             irq_pending,
  output logic [IDX_W-1:0] irq_index,
  output logic [N-1:0]     req_reg,
  output logic [N-1:0]     isr_reg
);

  logic [N-1:0]     req_clr_vec;
  logic [N-1:0]     isr_q;
  logic [IDX_W-1:0] top_q;
  logic             isr_any;
  logic [IDX_W-1:0] isr_hi_idx;
  logic             pend;
  logic [IDX_W-1:0] win_idx;

  irq_req_capture #(.N(N)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_line (irq_line),
    .edge_mode(edge_mode),
    .clr_vec  (req_clr_vec),
    .req_q    (req_reg)
  );

  irq_prio_select #(.N(N)) u_select (
    .req_vec   (req_reg),
    .mask_vec  (mask),
    .isr_vec   (isr_q),
    .top_idx   (top_q),
    .pend      (pend),
    .win_idx   (win_idx),
    .isr_any   (isr_any),
    .isr_hi_idx(isr_hi_idx)
  );

  irq_service_ctl #(.N(N)) u_service (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .pend        (pend),
    .win_idx     (win_idx),
    .auto_release(auto_release),
    .rotate_en   (rotate_en),
    .eoi_valid   (eoi_valid),
    .eoi_specific(eoi_specific),
    .eoi_index   (eoi_index),
    .isr_any     (isr_any),
    .isr_hi_idx  (isr_hi_idx),
    .prio_load   (prio_load),
    .prio_top    (prio_top),
    .isr_q       (isr_q),
    .top_q       (top_q),
    .req_clr_vec (req_clr_vec)
  );

  assign irq_pending = pend;
  assign irq_index   = win_idx;
  assign isr_reg     = isr_q;

  // True when idx outranks every line set in isr under base pointer top.
  function automatic logic outranks_all(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] top, logic [N-1:0] isr);
    logic ok;
    ok = 1'b1;
    for (int unsigned b = 0; b < N; b++) begin
      if (isr[b] && rank_of(b, 32'(top), N) <= rank_of(32'(idx), 32'(top), N)) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req_reg[irq_index] && !mask[irq_index]))
    else $error("offered line masked or not requesting"); // R3

  AST_NEST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> outranks_all(irq_index, top_q, isr_reg))
    else $error("offered line does not outrank service"); // R4

  AST_NO_REQ_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_reg & ~mask) == '0) |-> !irq_pending)
    else $error("offer without unmasked request"); // R2

endmodule

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_line;
  logic       edge_mode;
  logic [7:0] mask;
  logic       auto_release;
  logic       rotate_en;
  logic       ack;
  logic       eoi_valid;
  logic       eoi_specific;
  logic [2:0] eoi_index;
  logic       prio_load;
  logic [2:0] prio_top;
  logic       irq_pending;
  logic [2:0] irq_index;
  logic [7:0] req_reg;
  logic [7:0] isr_reg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_line    (irq_line),
    .edge_mode   (edge_mode),
    .mask        (mask),
    .auto_release(auto_release),
    .rotate_en   (rotate_en),
    .ack         (ack),
    .eoi_valid   (eoi_valid),
    .eoi_specific(eoi_specific),
    .eoi_index   (eoi_index),
    .prio_load   (prio_load),
    .prio_top    (prio_top),
    .irq_pending (irq_pending),
    .irq_index   (irq_index),
    .req_reg     (req_reg),
    .isr_reg     (isr_reg)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // First requesting line scanning circularly from top; -1 when none.
  function automatic int exp_win(int pat, int top);
    for (int k = 0; k < 8; k++) begin
      if (pat[(top + k) % 8]) return (top + k) % 8;
    end
    return -1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; irq_line = '0; edge_mode = 1'b0; mask = '0;
    auto_release = 1'b0; rotate_en = 1'b0; ack = 1'b0;
    eoi_valid = 1'b0; eoi_specific = 1'b0; eoi_index = '0;
    prio_load = 1'b0; prio_top = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic release_cmd(logic spec, int idx);
    eoi_valid = 1'b1; eoi_specific = spec; eoi_index = 3'(idx);
    tick();
    eoi_valid = 1'b0; eoi_specific = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 req", int'(req_reg), 0);
    chk("R1 isr", int'(isr_reg), 0);
    chk("R1 pend", int'(irq_pending), 0);

    // R2: fixed order sweep, all patterns
    for (int p = 1; p < 256; p++) begin
      irq_line = 8'(p); tick();
      chk("R2 req", int'(req_reg), p);
      chk("R2 win", int'(irq_index), exp_win(p, 0));
    end
    irq_line = '0; tick();
    chk("R2 idle pend", int'(irq_pending), 0);

    // R3: mask sweep with all lines requesting
    irq_line = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      mask = 8'(m); tick();
      chk("R3 req", int'(req_reg), 255);
      chk("R3 pend", int'(irq_pending), (m != 255) ? 1 : 0);
      if (m != 255) chk("R3 win", int'(irq_index), exp_win(~m & 255, 0));
    end
    mask = '0;

    // R10: base pointer load, every top and pattern
    for (int t = 1; t < 8; t++) begin
      prio_load = 1'b1; prio_top = 3'(t); tick(); prio_load = 1'b0;
      for (int p = 1; p < 256; p++) begin
        irq_line = 8'(p); tick();
        chk("R10 win", int'(irq_index), exp_win(p, t));
      end
    end

    // R4: line 3 in service blocks equal and lower ranks
    do_reset();
    irq_line = 8'h08; tick();
    pulse_ack();
    chk("R5 isr", int'(isr_reg), 8'h08);
    for (int p = 1; p < 256; p++) begin
      int w;
      irq_line = 8'(p); tick();
      w = exp_win(p, 0);
      chk("R4 pend", int'(irq_pending), (w < 3) ? 1 : 0);
      if (w < 3) chk("R4 win", int'(irq_index), w);
    end

    // R9 / R5: edge capture
    do_reset();
    edge_mode = 1'b1;
    irq_line = 8'h24; tick();
    chk("R9 req", int'(req_reg), 8'h24);
    chk("R9 win", int'(irq_index), 2);
    pulse_ack();
    chk("R5 isr", int'(isr_reg), 8'h04);
    chk("R5 req", int'(req_reg), 8'h20);
    chk("R4 blocked", int'(irq_pending), 0);
    repeat (3) tick();
    chk("R9 no relatch", int'(req_reg), 8'h20);
    release_cmd(1'b1, 2);
    chk("R6 spec", int'(isr_reg), 0);
    chk("R9 pend", int'(irq_pending), 1);
    chk("R9 win5", int'(irq_index), 5);
    irq_line = 8'h20; tick();
    irq_line = 8'h24; tick();
    chk("R9 relatch", int'(req_reg), 8'h24);

    // R6: nested service, release order
    do_reset();
    edge_mode = 1'b1;
    irq_line = 8'h80; tick(); pulse_ack();
    irq_line = 8'h88; tick();
    chk("R4 nest pend", int'(irq_pending), 1);
    pulse_ack();
    irq_line = 8'h89; tick(); pulse_ack();
    chk("R6 stack", int'(isr_reg), 8'h89);
    release_cmd(1'b0, 0);
    chk("R6 ns1", int'(isr_reg), 8'h88);
    release_cmd(1'b1, 7);
    chk("R6 spec7", int'(isr_reg), 8'h08);
    release_cmd(1'b0, 0);
    chk("R6 ns2", int'(isr_reg), 0);

    // R7: automatic release
    do_reset();
    edge_mode = 1'b1; auto_release = 1'b1;
    irq_line = 8'h10; tick();
    pulse_ack();
    chk("R7 isr", int'(isr_reg), 0);
    chk("R7 req", int'(req_reg), 0);
    chk("R7 pend", int'(irq_pending), 0);

    // R12: acknowledge with nothing offered
    do_reset();
    pulse_ack();
    chk("R12 isr idle", int'(isr_reg), 0);
    mask = 8'hFF; irq_line = 8'h01; tick();
    pulse_ack();
    chk("R12 isr masked", int'(isr_reg), 0);
    chk("R12 req kept", int'(req_reg), 1);

    // R8: level line re-offered after release
    do_reset();
    irq_line = 8'h01; tick();
    pulse_ack();
    chk("R8 isr", int'(isr_reg), 1);
    tick();
    chk("R8 req", int'(req_reg), 1);
    chk("R8 blocked", int'(irq_pending), 0);
    release_cmd(1'b0, 0);
    chk("R8 isr clr", int'(isr_reg), 0);
    chk("R8 reoffer", int'(irq_pending), 1);
    chk("R8 win", int'(irq_index), 0);

    // R11: rotation with automatic release, lines 1 and 3 held
    do_reset();
    rotate_en = 1'b1; auto_release = 1'b1;
    irq_line = 8'h0A; tick();
    chk("R11 first", int'(irq_index), 1);
    pulse_ack();
    chk("R11 after1", int'(irq_index), 3);
    tick();
    chk("R11 rotated", int'(irq_index), exp_win(8'h0A, 2));
    pulse_ack();
    tick();
    chk("R11 rotated2", int'(irq_index), exp_win(8'h0A, 4));

    // R11: rotation on explicit release
    do_reset();
    rotate_en = 1'b1;
    irq_line = 8'h41; tick();
    pulse_ack();
    release_cmd(1'b1, 0);
    tick();
    chk("R11 eoi rot", int'(irq_index), 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule